// File: doc/BRIEF.md
# Pipelined Bitmap Popcount and First-One Finder

This block takes a 28-bit presence bitmap, such as the child-occupancy vector of a trie node, and returns two results. The first is how many bits are set. The second is the position of the lowest set bit, where bit 0 is the least significant bit. A zero flag marks a bitmap with no bits set. All results leave a five-stage pipeline together with a valid strobe. A new bitmap can be accepted on every clock, so a lookup engine can stream node vectors into it without stalling.

The ones count starts from seven 4-bit groups. Each group's count comes from a computed 16-entry lookup, and the seven counts are then summed in a registered adder tree of four, two and one adders. The first-one position comes from a registered halving search over windows of 28, 14, 7, 4 and 2 bits. Each stage tests whether the lower part of its window is non-zero, keeps the lower part when it is, and adds the size of the lower part to a running offset when it is not. A thin top connects a valid-tracking control module to a datapath that holds the count tree and the search.

Top module: `bitmap_scan`

## Requirements
- R1: When `outValid` is high, `onesCount` equals the number of set bits in the accepted `inVec` (0 to 28, 5 bits).
- R2: When `outValid` is high and the accepted vector is non-zero, `firstIdx` is the lowest bit position that is set, with bit 0 as the least significant bit.
- R3: When the accepted vector is all zeros, `isZero` is 1, `firstIdx` is 0 and `onesCount` is 0. Otherwise `isZero` is 0.
- R4: A vector sampled with `inValid` high at rising edge k produces `outValid` high, with its results, right after rising edge k+4, which is a latency of five edges.
- R5: Vectors presented on consecutive clocks produce results on consecutive clocks, in the order they were accepted.
- R6: A clock edge with `inValid` low accepts nothing. The value of `inVec` has no effect, five edges later `outValid` is low, and `onesCount`, `firstIdx` and `isZero` keep their previous values.
- R7: While `rst` (synchronous, active high) is asserted, `outValid` is 0, `onesCount` is 0, `firstIdx` is 0 and `isZero` is 1.
- R8: The index is correct for set bits on either side of every halving boundary (bits 13/14, 6/7, 20/21, 2/3, 9/10, 16/17, 23/24) and at the top position, bit 27.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Marks `inVec` as a vector to process |
| inVec | input | 28 | Bitmap to scan |
| outValid | output | 1 | Results below belong to an accepted vector |
| onesCount | output | 5 | Number of set bits |
| firstIdx | output | 5 | Position of the lowest set bit |
| isZero | output | 1 | Accepted vector had no set bits |

## Verification
The all-zero and all-ones vectors test the zero flag against the full count of 28. Each of the 28 one-hot vectors pins down one index value and shows whether every search decision steers correctly. Pairs of set bits that straddle each halving boundary show whether the lower part is preferred at each level. A long back-to-back stream of sparse random vectors, with idle gaps that carry garbage on `inVec`, separates a correct pipeline from one that drops results, duplicates them, reorders them or leaks idle data into its held outputs.

// File: rtl/bitscan_pkg.sv
package bitscan_pkg;
  localparam int VEC_W    = 28;
  localparam int NIB_W    = 4;
  localparam int NUM_NIB  = VEC_W / NIB_W;
  localparam int NIBCNT_W = 3;
  localparam int LUT_N    = 1 << NIB_W;
  localparam int CNT_W    = 5;
  localparam int IDX_W    = 5;
  localparam int STAGES   = 5;

  typedef struct packed {
    logic [STAGES-1:0] load;  // load[s]: stage s registers capture
  } stageStrobe_t;

  // Per-nibble ones count table, computed rather than listed.
  function automatic logic [LUT_N*NIBCNT_W-1:0] buildNibLut();
    logic [LUT_N*NIBCNT_W-1:0] t;
    t = '0;
    for (int v = 0; v < LUT_N; v++) begin
      int c;
      c = 0;
      for (int b = 0; b < NIB_W; b++) c += (v >> b) & 1;
      t[v*NIBCNT_W +: NIBCNT_W] = NIBCNT_W'(c);
    end
    return t;
  endfunction
endpackage

// File: rtl/bitscan_ctrl.sv
module bitscan_ctrl
  import bitscan_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  output stageStrobe_t strobe,
  output logic         outValid
);
  logic [STAGES-1:0] validPipe;
  logic [2:0]        warmCnt;

  always_ff @(posedge clk) begin
    if (rst) validPipe <= '0;
    else     validPipe <= {validPipe[STAGES-2:0], inValid};
  end

  always_comb begin
    strobe.load[0] = inValid;
    for (int s = 1; s < STAGES; s++) strobe.load[s] = validPipe[s-1];
  end

  assign outValid = validPipe[STAGES-1];

  // Edges since reset, saturating; only used to guard the latency check.
  always_ff @(posedge clk) begin
    if (rst) warmCnt <= '0;
    else if (warmCnt != 3'(STAGES)) warmCnt <= warmCnt + 3'd1;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (warmCnt == 3'(STAGES)) |-> (outValid == $past(inValid, 5))); // R4
  AST_LOAD_ORDER: assert property (@(posedge clk) disable iff (rst)
    strobe.load[0] |=> strobe.load[1]); // R5
endmodule

// File: rtl/bitscan_count.sv
module bitscan_count
  import bitscan_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  stageStrobe_t       strobe,
  input  logic [VEC_W-1:0]   inVec,
  output logic [CNT_W-1:0]   onesCount
);
  localparam logic [LUT_N*NIBCNT_W-1:0] NIB_LUT = buildNibLut();
  localparam int L1_N = (NUM_NIB + 1) / 2;
  localparam int L2_N = (L1_N + 1) / 2;
  localparam int L1_W = NIBCNT_W + 1;
  localparam int L2_W = L1_W + 1;

  logic [NIBCNT_W-1:0] nibQ [NUM_NIB];
  logic [L1_W-1:0]     l1Q  [L1_N];
  logic [L2_W-1:0]     l2Q  [L2_N];
  logic [CNT_W-1:0]    l3Q;
  logic [CNT_W-1:0]    outQ;

  // Level 0: per-nibble lookup.
  for (genvar g = 0; g < NUM_NIB; g++) begin : g_nib
    logic [NIB_W-1:0] nib;
    assign nib = inVec[g*NIB_W +: NIB_W];
    always_ff @(posedge clk) begin
      if (rst) nibQ[g] <= '0;
      else if (strobe.load[0])
        nibQ[g] <= NIB_LUT[NIBCNT_W*int'(nib) +: NIBCNT_W];
    end
  end

  // Level 1: four adders (the last takes a single operand).
  for (genvar a = 0; a < L1_N; a++) begin : g_l1
    logic [L1_W-1:0] opB;
    if (2*a + 1 < NUM_NIB) begin : g_pair
      assign opB = L1_W'(nibQ[2*a+1]);
    end else begin : g_single
      assign opB = '0;
    end
    always_ff @(posedge clk) begin
      if (rst) l1Q[a] <= '0;
      else if (strobe.load[1]) l1Q[a] <= L1_W'(nibQ[2*a]) + opB;
    end
  end

  // Level 2: two adders.
  for (genvar a = 0; a < L2_N; a++) begin : g_l2
    always_ff @(posedge clk) begin
      if (rst) l2Q[a] <= '0;
      else if (strobe.load[2]) l2Q[a] <= L2_W'(l1Q[2*a]) + L2_W'(l1Q[2*a+1]);
    end
  end

  // Level 3: final adder, then an alignment register to match the search.
  always_ff @(posedge clk) begin
    if (rst) begin
      l3Q  <= '0;
      outQ <= '0;
    end else begin
      if (strobe.load[3]) l3Q <= CNT_W'(l2Q[0]) + CNT_W'(l2Q[1]);
      if (strobe.load[4]) outQ <= l3Q;
    end
  end

  assign onesCount = outQ;

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    onesCount <= CNT_W'(VEC_W)); // R1
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobe.load[4] |=> $stable(onesCount)); // R6
endmodule

// File: rtl/bitscan_search.sv
module bitscan_search
  import bitscan_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  stageStrobe_t       strobe,
  input  logic [VEC_W-1:0]   inVec,
  output logic [IDX_W-1:0]   firstIdx,
  output logic               isZero
);
  localparam int W1   = VEC_W / 2;   // 14
  localparam int W2   = W1 / 2;      // 7
  localparam int W3LO = W2 / 2;      // 3
  localparam int W3   = W2 - W3LO;   // 4
  localparam int W4   = W3 / 2;      // 2

  logic [W1-1:0]    cand1;
  logic [W2-1:0]    cand2;
  logic [W3-1:0]    cand3;
  logic [W4-1:0]    cand4;
  logic [IDX_W-1:0] base1, base2, base3, base4, idxQ;
  logic             zero1, zero2, zero3, zero4, zeroQ;

  logic lowNz1, lowNz2, lowNz3, lowNz4;
  assign lowNz1 = |inVec[W1-1:0];
  assign lowNz2 = |cand1[W2-1:0];
  assign lowNz3 = |cand2[W3LO-1:0];
  assign lowNz4 = |cand3[W4-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cand1 <= '0; base1 <= '0; zero1 <= 1'b1;
    end else if (strobe.load[0]) begin
      cand1 <= lowNz1 ? inVec[W1-1:0] : inVec[VEC_W-1:W1];
      base1 <= lowNz1 ? '0 : IDX_W'(W1);
      zero1 <= ~(|inVec);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cand2 <= '0; base2 <= '0; zero2 <= 1'b1;
    end else if (strobe.load[1]) begin
      cand2 <= lowNz2 ? cand1[W2-1:0] : cand1[W1-1:W2];
      base2 <= base1 + (lowNz2 ? '0 : IDX_W'(W2));
      zero2 <= zero1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cand3 <= '0; base3 <= '0; zero3 <= 1'b1;
    end else if (strobe.load[2]) begin
      cand3 <= lowNz3 ? W3'(cand2[W3LO-1:0]) : cand2[W2-1:W3LO];
      base3 <= base2 + (lowNz3 ? '0 : IDX_W'(W3LO));
      zero3 <= zero2;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cand4 <= '0; base4 <= '0; zero4 <= 1'b1;
    end else if (strobe.load[3]) begin
      cand4 <= lowNz4 ? cand3[W4-1:0] : cand3[W3-1:W4];
      base4 <= base3 + (lowNz4 ? '0 : IDX_W'(W4));
      zero4 <= zero3;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idxQ <= '0; zeroQ <= 1'b1;
    end else if (strobe.load[4]) begin
      idxQ  <= zero4 ? '0 : base4 + (cand4[0] ? '0 : IDX_W'(1));
      zeroQ <= zero4;
    end
  end

  assign firstIdx = idxQ;
  assign isZero   = zeroQ;

  AST_ZERO_IDX: assert property (@(posedge clk) disable iff (rst)
    isZero |-> (firstIdx == '0)); // R3
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    firstIdx < IDX_W'(VEC_W)); // R2
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobe.load[4] |=> ($stable(firstIdx) && $stable(isZero))); // R6
endmodule

// File: rtl/bitscan_datapath.sv
module bitscan_datapath
  import bitscan_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  stageStrobe_t       strobe,
  input  logic [VEC_W-1:0]   inVec,
  output logic [CNT_W-1:0]   onesCount,
  output logic [IDX_W-1:0]   firstIdx,
  output logic               isZero
);
  bitscan_count u_count (
    .clk(clk), .rst(rst), .strobe(strobe), .inVec(inVec), .onesCount(onesCount)
  );

  bitscan_search u_search (
    .clk(clk), .rst(rst), .strobe(strobe), .inVec(inVec),
    .firstIdx(firstIdx), .isZero(isZero)
  );

  // Count tree and search pipe are independent; their zero views must agree.
  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (rst)
    isZero == (onesCount == '0)); // R3
endmodule

// File: rtl/bitmap_scan.sv
module bitmap_scan
  import bitscan_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [27:0]      inVec,
  output logic             outValid,
  output logic [4:0]       onesCount,
  output logic [4:0]       firstIdx,
  output logic             isZero
);
  stageStrobe_t strobe;

  bitscan_ctrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .strobe(strobe), .outValid(outValid)
  );

  bitscan_datapath u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .inVec(inVec),
    .onesCount(onesCount), .firstIdx(firstIdx), .isZero(isZero)
  );

  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (!outValid && onesCount == '0 && firstIdx == '0 && isZero)); // R7
endmodule

// File: tb/bitmap_scan_test.sv
module bitmap_scan_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [27:0] inVec = '0;
  logic        outValid;
  logic [4:0]  onesCount, firstIdx;
  logic        isZero;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;

  string phaseTag = "R1";

  bit          histV[$];
  logic [27:0] histD[$];
  string       histT[$];

  int lastCnt = 0, lastIdx = 0, lastZero = 1;

  always #5 clk = ~clk;

  bitmap_scan uut (
    .clk(clk), .rst(rst), .inValid(inValid), .inVec(inVec),
    .outValid(outValid), .onesCount(onesCount), .firstIdx(firstIdx), .isZero(isZero)
  );

  function automatic int refCount(logic [27:0] v);
    int c = 0;
    for (int i = 0; i < 28; i++) c += int'(v[i]);
    return c;
  endfunction

  function automatic int refFirst(logic [27:0] v);
    for (int i = 0; i < 28; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  // Model history: one entry per post-reset edge.
  always @(posedge clk) begin
    cyc++;
    if (!rst) begin
      histV.push_back(inValid);
      histD.push_back(inVec);
      histT.push_back(phaseTag);
    end
  end

  // Compare against the model on every clock, away from the edge.
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (histV.size() >= 5 && histV[histV.size()-5]) begin
        logic [27:0] v;
        string t;
        v = histD[histD.size()-5];
        t = histT[histT.size()-5];
        lastCnt  = refCount(v);
        lastIdx  = refFirst(v);
        lastZero = (v == '0) ? 1 : 0;
        check((t == "R5") ? "R5" : "R4", "outValid", int'(outValid), 1);
        check((t == "R5") ? "R5" : "R1", "onesCount", int'(onesCount), lastCnt);
        check((t == "R8") ? "R8" : "R2", "firstIdx", int'(firstIdx), lastIdx);
        check("R3", "isZero", int'(isZero), lastZero);
      end else begin
        check("R6", "outValid idle", int'(outValid), 0);
        check("R6", "onesCount held", int'(onesCount), lastCnt);
        check("R6", "firstIdx held", int'(firstIdx), lastIdx);
        check("R6", "isZero held", int'(isZero), lastZero);
      end
    end
  end

  task automatic send(logic [27:0] v);
    @(negedge clk);
    inValid = 1'b1;
    inVec   = v;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      inVec   = 28'($urandom());
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 20000) begin
      bad++;
      total++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      summary();
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    // R7: reset state
    check("R7", "outValid in reset", int'(outValid), 0);
    check("R7", "onesCount in reset", int'(onesCount), 0);
    check("R7", "firstIdx in reset", int'(firstIdx), 0);
    check("R7", "isZero in reset", int'(isZero), 1);
    rst = 1'b0;
    inVec = 28'hABCDEF1;   // garbage while idle, R6
    idle(6);

    phaseTag = "R3";
    send(28'h0);
    phaseTag = "R1";
    send(28'hFFFFFFF);
    idle(2);

    phaseTag = "R2";
    for (int b = 0; b < 28; b++) send(28'(1) << b);
    idle(3);

    phaseTag = "R8";
    send((28'(1) << 13) | (28'(1) << 14));
    send(28'(1) << 14);
    send((28'(1) << 6) | (28'(1) << 7));
    send((28'(1) << 20) | (28'(1) << 21));
    send(28'(1) << 21);
    send((28'(1) << 2) | (28'(1) << 3));
    send((28'(1) << 9) | (28'(1) << 10));
    send((28'(1) << 16) | (28'(1) << 17));
    send((28'(1) << 23) | (28'(1) << 24));
    send(28'(1) << 24);
    send(28'(1) << 27);
    send((28'(1) << 27) | (28'(1) << 26));
    idle(4);

    phaseTag = "R5";
    for (int i = 0; i < 200; i++) begin
      logic [27:0] v;
      v = 28'($urandom()) & 28'($urandom()) & 28'($urandom());
      if (i % 17 == 0) v = '0;
      send(v);
    end
    idle(5);

    phaseTag = "R6";
    for (int i = 0; i < 40; i++) begin
      send(28'($urandom()));
      idle(1 + (i % 3));
    end
    idle(10);
    summary();
  end
endmodule